// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block produces the six arithmetic status flags for an add or subtract of two operands. The operation can be eight or sixteen bits wide. The flags are carry/borrow, even parity, auxiliary (nibble) carry, zero, sign and signed overflow. The block also holds a sixteen-bit flag word. In that word the status flags sit beside three control flags: single-step trap, interrupt enable and string direction. A direction value of 0 means string pointers step upward, and 1 means they step downward.

An execution stage drives the two operands, the operation and the width every cycle. It raises the update strobe on the cycles whose result should be recorded. Each control flag has its own set and clear inputs. A full-word load writes every defined flag at once, for example when a saved flag word is restored. The registered word is always visible on the output, and its undefined bits read a fixed pattern.

Top module: `asf_flag_unit`

## Requirements
- R1: While reset is low and after it is released, all nine defined flags are 0, so the word reads 0x0002.
- R2: Bit 0 (carry) holds the carry out of the most significant bit of the selected width after an add. After a subtract it holds the borrow (1 when the unsigned minuend is smaller than the subtrahend).
- R3: Bit 2 (parity) is 1 when bits 7:0 of the result hold an even number of ones and 0 otherwise. This holds in both widths.
- R4: Bit 4 (auxiliary) holds the carry or borrow from result bit 3 into bit 4.
- R5: Bit 6 (zero) is 1 exactly when all result bits of the selected width are 0. Bit 7 (sign) copies the most significant result bit of the selected width.
- R6: Bit 11 (overflow) is 1 when the signed result does not fit the selected width. For an add this means equal operand signs with a result sign that differs from them. For a subtract it means different operand signs with a result sign that differs from the minuend.
- R7: With the width select low (8-bit), operand bits 15:8 have no effect on any flag. With it high, all sixteen bits take part.
- R8: The status flags change only at a clock edge where the update strobe or the load is high, and otherwise keep their value.
- R9: Trap (bit 8), interrupt (bit 9) and direction (bit 10) change only through their own set and clear inputs or the load. Set wins when set and clear are both high.
- R10: A load writes the nine defined flags from the load data and takes priority over the update strobe and over every set and clear input.
- R11: Bit 1 always reads 1 and bits 3, 5 and 15:12 always read 0, whatever is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 16 | First operand (minuend for subtract) |
| op_b | input | 16 | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| upd | input | 1 | Record the status flags of this cycle's operation |
| tf_set | input | 1 | Set trap flag |
| tf_clr | input | 1 | Clear trap flag |
| if_set | input | 1 | Set interrupt-enable flag |
| if_clr | input | 1 | Clear interrupt-enable flag |
| df_set | input | 1 | Set direction flag |
| df_clr | input | 1 | Clear direction flag |
| ld_en | input | 1 | Load the whole flag word |
| ld_data | input | 16 | Flag word to load |
| flags_out | output | 16 | Registered flag word |

## Verification
The hardest cases to reach from the ports are cycles where several writers collide. Examples are a load arriving together with an update and with set and clear on the same control flag, or an 8-bit operation whose upper operand bytes are non-zero and would change the flags if they leaked in. The random stimulus draws load, strobe and each set or clear input on their own, with biased odds. Collisions therefore recur many times, and the upper operand bytes are always random. Directed cases cover carry-into-zero, borrow, nibble carry, signed overflow in each direction, and parity of a 16-bit result whose low byte is zero.

// File: rtl/asf_pkg.sv
package asf_pkg;

    localparam int CF_POS = 0;
    localparam int PF_POS = 2;
    localparam int AF_POS = 4;
    localparam int ZF_POS = 6;
    localparam int SF_POS = 7;
    localparam int TF_POS = 8;
    localparam int IF_POS = 9;
    localparam int DF_POS = 10;
    localparam int OF_POS = 11;

    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] STATUS_MASK = 16'h08D5;
    localparam logic [WORD_W-1:0] CTRL_MASK   = 16'h0700;
    localparam logic [WORD_W-1:0] DEF_MASK    = STATUS_MASK | CTRL_MASK;
    localparam logic [WORD_W-1:0] FIXED_PAT   = 16'h0002;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } status_t;

    localparam int CTRL_N = 3;

endpackage

// File: rtl/asf_status_calc.sv
module asf_status_calc
    import asf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int AUX_BIT  = 4
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              op_wide,
    output status_t           st
);

    localparam int HI_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] a_m, b_m, res;
    logic [DATA_W:0]   full;
    logic              a_s, b_s, r_s;

    always_comb begin
        a_m  = op_wide ? op_a : {{HI_W{1'b0}}, op_a[NARROW_W-1:0]};
        b_m  = op_wide ? op_b : {{HI_W{1'b0}}, op_b[NARROW_W-1:0]};
        full = op_sub ? ({1'b0, a_m} - {1'b0, b_m}) : ({1'b0, a_m} + {1'b0, b_m});
        res  = full[DATA_W-1:0];

        a_s  = op_wide ? a_m[DATA_W-1] : a_m[NARROW_W-1];
        b_s  = op_wide ? b_m[DATA_W-1] : b_m[NARROW_W-1];
        r_s  = op_wide ? res[DATA_W-1] : res[NARROW_W-1];

        st.cry = op_wide ? full[DATA_W] : full[NARROW_W];
        st.par = ~^res[NARROW_W-1:0];
        st.aux = a_m[AUX_BIT] ^ b_m[AUX_BIT] ^ res[AUX_BIT];
        st.zro = op_wide ? (res == '0) : (res[NARROW_W-1:0] == '0);
        st.sgn = r_s;
        st.ovf = op_sub ? ((a_s != b_s) && (r_s != a_s))
                        : ((a_s == b_s) && (r_s != a_s));
    end

endmodule

// File: rtl/asf_status_reg.sv
module asf_status_reg
    import asf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd,
    input  logic    ld_en,
    input  status_t ld_st,
    input  status_t calc_st,
    output status_t st_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (ld_en) begin
            st_q <= ld_st;
        end else if (upd) begin
            st_q <= calc_st;
        end
    end

endmodule

// File: rtl/asf_ctrl_bit.sv
module asf_ctrl_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_en,
    input  logic ld_val,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (ld_en) begin
            q <= ld_val;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/asf_flag_unit.sv
module asf_flag_unit
    import asf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              op_wide,
    input  logic              upd,
    input  logic              tf_set,
    input  logic              tf_clr,
    input  logic              if_set,
    input  logic              if_clr,
    input  logic              df_set,
    input  logic              df_clr,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] flags_out
);

    localparam int CTRL_POS [CTRL_N] = '{TF_POS, IF_POS, DF_POS};

    status_t             calc_st, ld_st, st_q;
    logic [CTRL_N-1:0]   set_v, clr_v, ctrl_q;

    assign set_v = {df_set, if_set, tf_set};
    assign clr_v = {df_clr, if_clr, tf_clr};

    always_comb begin
        ld_st.cry = ld_data[CF_POS];
        ld_st.par = ld_data[PF_POS];
        ld_st.aux = ld_data[AF_POS];
        ld_st.zro = ld_data[ZF_POS];
        ld_st.sgn = ld_data[SF_POS];
        ld_st.ovf = ld_data[OF_POS];
    end

    asf_status_calc #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) calc_i (
        .op_a    (op_a),
        .op_b    (op_b),
        .op_sub  (op_sub),
        .op_wide (op_wide),
        .st      (calc_st)
    );

    asf_status_reg sreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .ld_en   (ld_en),
        .ld_st   (ld_st),
        .calc_st (calc_st),
        .st_q    (st_q)
    );

    for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
        asf_ctrl_bit cbit_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_en  (ld_en),
            .ld_val (ld_data[CTRL_POS[g]]),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .q      (ctrl_q[g])
        );
    end

    always_comb begin
        flags_out         = FIXED_PAT;
        flags_out[CF_POS] = st_q.cry;
        flags_out[PF_POS] = st_q.par;
        flags_out[AF_POS] = st_q.aux;
        flags_out[ZF_POS] = st_q.zro;
        flags_out[SF_POS] = st_q.sgn;
        flags_out[OF_POS] = st_q.ovf;
        for (int k = 0; k < CTRL_N; k++) begin
            flags_out[CTRL_POS[k]] = ctrl_q[k];
        end
    end

endmodule

// File: rtl/asf_flag_unit_chk.sv
module asf_flag_unit_chk
    import asf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              upd,
    input logic              tf_set,
    input logic              tf_clr,
    input logic              if_set,
    input logic              if_clr,
    input logic              df_set,
    input logic              df_clr,
    input logic              ld_en,
    input logic [WORD_W-1:0] ld_data,
    input logic [WORD_W-1:0] flags_out
);

    // R11
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out & ~DEF_MASK) == FIXED_PAT);

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !ld_en) |=> $stable(flags_out & STATUS_MASK));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !tf_set && !tf_clr && !if_set && !if_clr && !df_set && !df_clr)
        |=> $stable(flags_out & CTRL_MASK));

    // R9
    df_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (df_set && !ld_en) |=> flags_out[DF_POS]);

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> flags_out == (($past(ld_data) & DEF_MASK) | FIXED_PAT));

    // R5
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ld_en) |=> !(flags_out[ZF_POS] && flags_out[SF_POS]));

    // R3
    zero_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ld_en) |=> (!flags_out[ZF_POS] || flags_out[PF_POS]));

endmodule

bind asf_flag_unit asf_flag_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (upd),
    .tf_set    (tf_set),
    .tf_clr    (tf_clr),
    .if_set    (if_set),
    .if_clr    (if_clr),
    .df_set    (df_set),
    .df_clr    (df_clr),
    .ld_en     (ld_en),
    .ld_data   (ld_data),
    .flags_out (flags_out)
);

// File: tb/asf_flag_unit_test.sv
`timescale 1ns/1ps
module asf_flag_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0, ld_data = '0;
    logic        op_sub = 0, op_wide = 0, upd = 0, ld_en = 0;
    logic        tf_set = 0, tf_clr = 0, if_set = 0, if_clr = 0, df_set = 0, df_clr = 0;
    logic [15:0] flags_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model = 16'h0002;

    always #2 clk = ~clk;

    asf_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .op_wide(op_wide), .upd(upd), .tf_set(tf_set), .tf_clr(tf_clr),
        .if_set(if_set), .if_clr(if_clr), .df_set(df_set), .df_clr(df_clr),
        .ld_en(ld_en), .ld_data(ld_data), .flags_out(flags_out)
    );

    function automatic logic [15:0] ref_status(input logic [15:0] a, input logic [15:0] b,
                                               input logic sub, input logic wide);
        logic [15:0] r;
        logic [16:0] f;
        logic c, z, s, o, as, bs;
        logic [15:0] v;
        if (wide) begin
            f  = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
            r  = f[15:0];
            c  = sub ? (a < b) : f[16];
            z  = (r == 16'h0);
            s  = r[15];
            as = a[15]; bs = b[15];
        end else begin
            f  = sub ? ({9'h0, a[7:0]} - {9'h0, b[7:0]}) : ({9'h0, a[7:0]} + {9'h0, b[7:0]});
            r  = {8'h0, f[7:0]};
            c  = sub ? (a[7:0] < b[7:0]) : f[8];
            z  = (f[7:0] == 8'h0);
            s  = f[7];
            as = a[7]; bs = b[7];
        end
        o = sub ? (as != bs && s != as) : (as == bs && s != as);
        v = '0;
        v[0]  = c;
        v[2]  = ($countones(r[7:0]) % 2 == 0);
        v[4]  = sub ? ({1'b0, a[3:0]} < {1'b0, b[3:0]}) : (({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15);
        v[6]  = z;
        v[7]  = s;
        v[11] = o;
        return v;
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_chk++;
        if (flags_out !== exp) begin
            n_fail++;
            $display("FAIL %s: flags_out=%h expected=%h", tag, flags_out, exp);
        end
    endtask

    task automatic idle_inputs();
        upd = 0; ld_en = 0;
        tf_set = 0; tf_clr = 0; if_set = 0; if_clr = 0; df_set = 0; df_clr = 0;
    endtask

    // drive at negedge, advance one rising edge, update model, sample 1 ns later
    task automatic step();
        logic [15:0] st;
        @(posedge clk);
        st = ref_status(op_a, op_b, op_sub, op_wide);
        if (ld_en) begin
            model = (ld_data & 16'h0FD5) | 16'h0002;
        end else begin
            if (upd) model = (model & ~16'h08D5) | st;
            if (tf_set) model[8] = 1'b1; else if (tf_clr) model[8] = 1'b0;
            if (if_set) model[9] = 1'b1; else if (if_clr) model[9] = 1'b0;
            if (df_set) model[10] = 1'b1; else if (df_clr) model[10] = 1'b0;
        end
        #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic arith(input logic [15:0] a, input logic [15:0] b,
                         input logic sub, input logic wide);
        op_a = a; op_b = b; op_sub = sub; op_wide = wide; upd = 1;
        step();
    endtask

    initial begin
        #40000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 during reset", 16'h0002);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", 16'h0002);

        arith(16'h007F, 16'h0001, 0, 0);
        check("R4 R6 8-bit 7F+01", 16'h0892);
        arith(16'h00FF, 16'h0001, 0, 0);
        check("R2 8-bit carry FF+01", 16'h0057);
        arith(16'h0000, 16'h0001, 1, 0);
        check("R2 8-bit borrow 00-01", 16'h0097);
        arith(16'h0100, 16'h0000, 0, 1);
        check("R3 parity from low byte", 16'h0006);
        arith(16'h0008, 16'h0008, 0, 1);
        check("R4 nibble carry", 16'h0012);
        arith(16'h1234, 16'h1234, 1, 1);
        check("R5 zero result", 16'h0046);
        arith(16'h8000, 16'h0001, 1, 1);
        check("R6 subtract overflow", 16'h0816);
        arith(16'h12FF, 16'h3401, 0, 0);
        check("R7 8-bit ignores upper bytes", 16'h0057);
        arith(16'h12FF, 16'h3401, 0, 1);
        check("R7 16-bit uses upper bytes", 16'h0016);

        op_a = 16'h7FFF; op_b = 16'h0001; op_wide = 1; op_sub = 0; upd = 0;
        step();
        check("R8 no strobe holds status", 16'h0016);

        df_set = 1; tf_set = 1; tf_clr = 1;
        step();
        check("R9 set wins, status kept", 16'h0516);
        if_set = 1; df_clr = 1;
        step();
        check("R9 clear direction", 16'h0316);

        ld_en = 1; ld_data = 16'hFFFF; upd = 1; op_a = 16'h0; op_b = 16'h0;
        tf_clr = 1; if_clr = 1; df_clr = 1;
        step();
        check("R10 load beats strobe and clears", 16'h0FD7);
        ld_en = 1; ld_data = 16'hF02A;
        step();
        check("R11 unused bits ignore load", 16'h0002);
        model = 16'h0002;

        for (int i = 0; i < 600; i++) begin
            op_a    = 16'($urandom);
            op_b    = 16'($urandom);
            op_sub  = 1'($urandom);
            op_wide = 1'($urandom);
            upd     = ($urandom % 4) != 0;
            ld_en   = ($urandom % 12) == 0;
            ld_data = 16'($urandom);
            tf_set  = ($urandom % 6) == 0;
            tf_clr  = ($urandom % 6) == 0;
            if_set  = ($urandom % 6) == 0;
            if_clr  = ($urandom % 6) == 0;
            df_set  = ($urandom % 6) == 0;
            df_clr  = ($urandom % 6) == 0;
            step();
            check("RND mixed traffic", model);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule